// File: doc/BRIEF.md
# Buffer descriptor ring manager

This block owns the on-chip descriptor store of an Ethernet-style DMA engine. The store has room for 128 descriptors, each made of four 16-bit words. A 2-bit size code divides the store at run time into a transmit ring at the low end and a receive ring above it. The block keeps the ring pointers, hands validated transmit descriptors to the DMA mover, and writes completion status back into them. On the receive side it cuts each incoming frame into buffers of a programmable maximum length and writes back the length and status of every buffer it uses.

The host reaches the store through a plain word-wide read/write port. Host word address `a` maps to byte offset `0xC00 + 2*a`, so descriptor `d` occupies bytes `0xC00 + 8*d` to `0xC07 + 8*d`. Within a descriptor, word 0 is control/status, word 1 is the length, word 2 is the low half of the buffer address and word 3 is the high half. Control bits: bit 15 ready, bit 14 last-in-frame, bit 2 receive alignment error, bit 0 carrier sense lost.

Top module: `bd_ring_mgr`

## Requirements
- R1: With size code c, descriptors 0 to (8<<c)-1 form the transmit ring (byte 0xC00 onward) and descriptors 8<<c to 127 form the receive ring (ending at byte 0xFFF). The first receive buffer after a reset or a size change lands in descriptor 8<<c.
- R2: The transmit pointer returns to descriptor 0 after descriptor (8<<c)-1; the receive pointer returns to descriptor 8<<c after descriptor 127.
- R3: Any change of the size code puts both ring pointers back at their ring starts and drops all open transmit frames.
- R4: A `tx_fetch_i` pulse on a ready descriptor raises `tx_desc_valid_o` for one cycle, one clock later, with `tx_len_o` = word 1, `tx_addr_o` = {word 3, word 2} and `tx_last_o` = bit 14; an odd transmit address raises no error.
- R5: A transmit descriptor whose length word is 0 is delivered with `tx_len_err_o` high; the block never writes any transmit length word.
- R6: A fetch on a descriptor with bit 15 clear raises `tx_stall_o` one clock later, produces no valid, and leaves the transmit pointer where it was.
- R7: At most two transmit frames may be open; a fetch that would open a third stalls until a descriptor with bit 14 set completes.
- R8: A `tx_done_i` pulse completes the oldest fetched descriptor: bit 15 is cleared and bit 0 takes `tx_csl_i` only if bit 14 is set, otherwise bit 0 is cleared.
- R9: A received frame of L bytes with maximum buffer length M uses ceil(L/M) ready receive descriptors; all but the last get word 1 = M and bit 14 clear, the last gets word 1 = the remainder and bit 14 set; bit 15 is cleared in each.
- R10: A receive descriptor whose word 2 is odd gets bit 2 set and raises `rx_buf_err_o` with its buffer.
- R11: While the current receive descriptor is not ready during a frame, `rx_stall_o` is high and nothing is written; the frame resumes once the host sets bit 15.
- R12: A host write stores the word in the addressed slot; a host read returns the word on `host_rdata_o` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the store |
| size_code_i | input | 2 | Transmit/receive split code |
| mrbl_i | input | 16 | Maximum receive buffer length in bytes |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 9 | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, one clock after the address |
| tx_fetch_i | input | 1 | Request the next transmit descriptor |
| tx_done_i | input | 1 | Oldest fetched transmit descriptor has been sent |
| tx_csl_i | input | 1 | Carrier sense lost on that transmission |
| tx_desc_valid_o | output | 1 | Fetched descriptor fields are valid |
| tx_stall_o | output | 1 | Fetch refused (not ready or frame limit) |
| tx_len_o | output | 16 | Fetched transmit length |
| tx_addr_o | output | 32 | Fetched transmit buffer address |
| tx_last_o | output | 1 | Fetched descriptor ends a frame |
| tx_len_err_o | output | 1 | Fetched length is zero |
| rx_frame_i | input | 1 | A received frame is to be placed |
| rx_frame_len_i | input | 16 | Length of that frame in bytes |
| rx_buf_valid_o | output | 1 | A receive buffer was assigned and written back |
| rx_buf_len_o | output | 16 | Bytes placed in that buffer |
| rx_buf_addr_o | output | 32 | Address of that buffer |
| rx_buf_err_o | output | 1 | That buffer address is odd |
| rx_busy_o | output | 1 | A frame is being split |
| rx_stall_o | output | 1 | Waiting for a ready receive descriptor |

## Verification
The assertions assume that `tx_done_i` arrives only when a fetched descriptor is still outstanding, that `mrbl_i` is nonzero and held steady while a frame is split, that the size code stays below the point where the transmit ring would swallow the store, and that the host does not write a descriptor in the same cycle the block writes it back. The bench keeps to this by pulsing done only after a matching fetch, changing the maximum length only between frames, and doing all host writes while both rings are idle or stalled on the descriptor being made ready.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int BD_DW  = 16;
  localparam int RDY_B  = 15;
  localparam int LAST_B = 14;
  localparam int AERR_B = 2;
  localparam int CSL_B  = 0;

  typedef struct packed {
    logic [BD_DW-1:0] addr_hi;
    logic [BD_DW-1:0] addr_lo;
    logic [BD_DW-1:0] len;
    logic [BD_DW-1:0] ctl;
  } bd_t;
endpackage

// File: rtl/bdr_mem.sv
module bdr_mem
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  localparam int IDX_W = $clog2(NUM_BD),
  localparam int AW    = IDX_W + 2,
  localparam int DEPTH = NUM_BD * 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [BD_DW-1:0] host_wdata_i,
  output logic [BD_DW-1:0] host_rdata_o,
  input  logic [IDX_W-1:0] tx_idx_i,
  output bd_t              tx_bd_o,
  input  logic [IDX_W-1:0] tail_idx_i,
  output logic [BD_DW-1:0] tail_ctl_o,
  input  logic [IDX_W-1:0] rx_idx_i,
  output bd_t              rx_bd_o,
  input  logic             tx_wb_en_i,
  input  logic [BD_DW-1:0] tx_wb_w0_i,
  input  logic             rx_wb_en_i,
  input  logic [BD_DW-1:0] rx_wb_w0_i,
  input  logic [BD_DW-1:0] rx_wb_w1_i
);
  logic [BD_DW-1:0] mem [DEPTH];

  assign tx_bd_o    = {mem[{tx_idx_i, 2'd3}], mem[{tx_idx_i, 2'd2}],
                       mem[{tx_idx_i, 2'd1}], mem[{tx_idx_i, 2'd0}]};
  assign rx_bd_o    = {mem[{rx_idx_i, 2'd3}], mem[{rx_idx_i, 2'd2}],
                       mem[{rx_idx_i, 2'd1}], mem[{rx_idx_i, 2'd0}]};
  assign tail_ctl_o = mem[{tail_idx_i, 2'd0}];

  // engine write-backs win over a host write to the same word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      host_rdata_o <= '0;
    end else begin
      host_rdata_o <= mem[host_addr_i];
      if (host_we_i) mem[host_addr_i] <= host_wdata_i;
      if (tx_wb_en_i) mem[{tail_idx_i, 2'd0}] <= tx_wb_w0_i;
      if (rx_wb_en_i) begin
        mem[{rx_idx_i, 2'd0}] <= rx_wb_w0_i;
        mem[{rx_idx_i, 2'd1}] <= rx_wb_w1_i;
      end
    end
  end
endmodule

// File: rtl/bdr_tx.sv
module bdr_tx
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  localparam int IDX_W = $clog2(NUM_BD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_chg_i,
  input  logic [IDX_W:0]   ntx_i,
  input  logic             fetch_i,
  input  logic             done_i,
  input  logic             csl_i,
  input  bd_t              head_bd_i,
  input  logic [BD_DW-1:0] tail_ctl_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             wb_en_o,
  output logic [BD_DW-1:0] wb_w0_o,
  output logic             valid_o,
  output logic             stall_o,
  output logic             last_o,
  output logic             len_err_o,
  output logic [BD_DW-1:0] len_o,
  output logic [31:0]      addr_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [1:0]       open_q;
  logic             in_frame_q;
  logic             head_end, tail_end, fetch_ok, opens, closes;

  assign head_o   = head_q;
  assign tail_o   = tail_q;
  assign head_end = ({1'b0, head_q} == ntx_i - 1'b1);
  assign tail_end = ({1'b0, tail_q} == ntx_i - 1'b1);
  // a new frame may not start while two are already open
  assign fetch_ok = fetch_i && head_bd_i.ctl[RDY_B] && (in_frame_q || open_q != 2'd2);
  assign opens    = fetch_ok && !in_frame_q;
  assign closes   = done_i && tail_ctl_i[LAST_B];

  assign wb_en_o = done_i && !cfg_chg_i;
  always_comb begin
    wb_w0_o        = tail_ctl_i;
    wb_w0_o[RDY_B] = 1'b0;
    wb_w0_o[CSL_B] = csl_i && tail_ctl_i[LAST_B];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0; tail_q <= '0; open_q <= '0; in_frame_q <= 1'b0;
      valid_o <= 1'b0; stall_o <= 1'b0; last_o <= 1'b0; len_err_o <= 1'b0;
      len_o <= '0; addr_o <= '0;
    end else if (cfg_chg_i) begin
      head_q <= '0; tail_q <= '0; open_q <= '0; in_frame_q <= 1'b0;
      valid_o <= 1'b0; stall_o <= 1'b0;
    end else begin
      valid_o <= fetch_ok;
      stall_o <= fetch_i && !fetch_ok;
      if (fetch_ok) begin
        len_o      <= head_bd_i.len;
        addr_o     <= {head_bd_i.addr_hi, head_bd_i.addr_lo};
        last_o     <= head_bd_i.ctl[LAST_B];
        len_err_o  <= (head_bd_i.len == '0);
        head_q     <= head_end ? '0 : head_q + 1'b1;
        in_frame_q <= !head_bd_i.ctl[LAST_B];
      end
      if (done_i) tail_q <= tail_end ? '0 : tail_q + 1'b1;
      open_q <= open_q + {1'b0, opens} - {1'b0, closes};
    end
  end

  p_open_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q <= 2'd2);
  p_head_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_chg_i |-> ({1'b0, head_q} < ntx_i));
  p_valid_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_o, stall_o}));
  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !$past(cfg_chg_i)) |-> (head_q == $past(head_q)));
endmodule

// File: rtl/bdr_rx.sv
module bdr_rx
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  localparam int IDX_W = $clog2(NUM_BD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_chg_i,
  input  logic [IDX_W:0]   ntx_i,
  input  logic             frame_i,
  input  logic [BD_DW-1:0] frame_len_i,
  input  logic [BD_DW-1:0] mrbl_i,
  input  bd_t              bd_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             wb_en_o,
  output logic [BD_DW-1:0] wb_w0_o,
  output logic [BD_DW-1:0] wb_w1_o,
  output logic             valid_o,
  output logic [BD_DW-1:0] len_o,
  output logic [31:0]      addr_o,
  output logic             err_o,
  output logic             busy_o,
  output logic             stall_o
);
  logic [IDX_W-1:0] rel_q;
  logic [BD_DW-1:0] rem_q, blen;
  logic             active_q, take, is_last, at_end;

  // pointer kept relative to the ring start so reset needs no size input
  assign idx_o   = ntx_i[IDX_W-1:0] + rel_q;
  assign at_end  = (idx_o == IDX_W'(NUM_BD - 1));
  assign take    = active_q && bd_i.ctl[RDY_B];
  assign is_last = (rem_q <= mrbl_i);
  assign blen    = is_last ? rem_q : mrbl_i;
  assign busy_o  = active_q;
  assign stall_o = active_q && !bd_i.ctl[RDY_B];

  assign wb_en_o = take && !cfg_chg_i;
  assign wb_w1_o = blen;
  always_comb begin
    wb_w0_o         = bd_i.ctl;
    wb_w0_o[RDY_B]  = 1'b0;
    wb_w0_o[LAST_B] = is_last;
    wb_w0_o[AERR_B] = bd_i.addr_lo[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '0; rem_q <= '0; active_q <= 1'b0;
      valid_o <= 1'b0; len_o <= '0; addr_o <= '0; err_o <= 1'b0;
    end else if (cfg_chg_i) begin
      rel_q <= '0; rem_q <= '0; active_q <= 1'b0; valid_o <= 1'b0;
    end else begin
      valid_o <= take;
      if (take) begin
        len_o    <= blen;
        addr_o   <= {bd_i.addr_hi, bd_i.addr_lo};
        err_o    <= bd_i.addr_lo[0];
        rel_q    <= at_end ? '0 : rel_q + 1'b1;
        rem_q    <= rem_q - blen;
        active_q <= !is_last;
      end else if (frame_i && !active_q && frame_len_i != '0) begin
        rem_q    <= frame_len_i;
        active_q <= 1'b1;
      end
    end
  end

  p_buf_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o != '0 && len_o <= mrbl_i));
  p_idx_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_chg_i |-> ({1'b0, idx_o} >= ntx_i));
  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !cfg_chg_i) |=> (rel_q == $past(rel_q)));
endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int MIN_TX = 8,
  localparam int IDX_W = $clog2(NUM_BD),
  localparam int AW    = IDX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       size_code_i,
  input  logic [BD_DW-1:0] mrbl_i,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [BD_DW-1:0] host_wdata_i,
  output logic [BD_DW-1:0] host_rdata_o,
  input  logic             tx_fetch_i,
  input  logic             tx_done_i,
  input  logic             tx_csl_i,
  output logic             tx_desc_valid_o,
  output logic             tx_stall_o,
  output logic [BD_DW-1:0] tx_len_o,
  output logic [31:0]      tx_addr_o,
  output logic             tx_last_o,
  output logic             tx_len_err_o,
  input  logic             rx_frame_i,
  input  logic [BD_DW-1:0] rx_frame_len_i,
  output logic             rx_buf_valid_o,
  output logic [BD_DW-1:0] rx_buf_len_o,
  output logic [31:0]      rx_buf_addr_o,
  output logic             rx_buf_err_o,
  output logic             rx_busy_o,
  output logic             rx_stall_o
);
  logic [1:0]       size_q;
  logic             cfg_chg;
  logic [IDX_W:0]   ntx;
  logic [IDX_W-1:0] tx_idx, tail_idx, rx_idx;
  bd_t              tx_bd, rx_bd;
  logic [BD_DW-1:0] tail_ctl, tx_wb_w0, rx_wb_w0, rx_wb_w1;
  logic             tx_wb_en, rx_wb_en;

  assign ntx     = (IDX_W + 1)'(MIN_TX) << size_code_i;
  assign cfg_chg = (size_code_i != size_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) size_q <= '0;
    else         size_q <= size_code_i;
  end

  bdr_mem #(.NUM_BD(NUM_BD)) u_mem (
    .clk_i, .rst_ni,
    .host_we_i, .host_addr_i, .host_wdata_i, .host_rdata_o,
    .tx_idx_i(tx_idx), .tx_bd_o(tx_bd),
    .tail_idx_i(tail_idx), .tail_ctl_o(tail_ctl),
    .rx_idx_i(rx_idx), .rx_bd_o(rx_bd),
    .tx_wb_en_i(tx_wb_en), .tx_wb_w0_i(tx_wb_w0),
    .rx_wb_en_i(rx_wb_en), .rx_wb_w0_i(rx_wb_w0), .rx_wb_w1_i(rx_wb_w1)
  );

  bdr_tx #(.NUM_BD(NUM_BD)) u_tx (
    .clk_i, .rst_ni, .cfg_chg_i(cfg_chg), .ntx_i(ntx),
    .fetch_i(tx_fetch_i), .done_i(tx_done_i), .csl_i(tx_csl_i),
    .head_bd_i(tx_bd), .tail_ctl_i(tail_ctl),
    .head_o(tx_idx), .tail_o(tail_idx),
    .wb_en_o(tx_wb_en), .wb_w0_o(tx_wb_w0),
    .valid_o(tx_desc_valid_o), .stall_o(tx_stall_o), .last_o(tx_last_o),
    .len_err_o(tx_len_err_o), .len_o(tx_len_o), .addr_o(tx_addr_o)
  );

  bdr_rx #(.NUM_BD(NUM_BD)) u_rx (
    .clk_i, .rst_ni, .cfg_chg_i(cfg_chg), .ntx_i(ntx),
    .frame_i(rx_frame_i), .frame_len_i(rx_frame_len_i), .mrbl_i,
    .bd_i(rx_bd), .idx_o(rx_idx),
    .wb_en_o(rx_wb_en), .wb_w0_o(rx_wb_w0), .wb_w1_o(rx_wb_w1),
    .valid_o(rx_buf_valid_o), .len_o(rx_buf_len_o), .addr_o(rx_buf_addr_o),
    .err_o(rx_buf_err_o), .busy_o(rx_busy_o), .stall_o(rx_stall_o)
  );

  p_ntx_fits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntx < (IDX_W + 1)'(NUM_BD));
endmodule

// File: tb/bd_ring_mgr_tb.sv
module bd_ring_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size = '0;
  logic [15:0] mrbl = 16'd64;
  logic        host_we = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        tx_fetch = 1'b0, tx_done = 1'b0, tx_csl = 1'b0;
  logic        tx_valid, tx_stall, tx_last, tx_err;
  logic [15:0] tx_len;
  logic [31:0] tx_addr;
  logic        rx_frame = 1'b0;
  logic [15:0] rx_len = '0;
  logic        rx_valid, rx_err, rx_busy, rx_stall;
  logic [15:0] rx_blen;
  logic [31:0] rx_baddr;

  int          n_chk = 0, n_fail = 0;
  logic [15:0] rd;
  logic [15:0] got_len [64];
  logic [31:0] got_addr [64];
  logic        got_err [64];
  int          got_n;

  always #5 clk = ~clk;

  bd_ring_mgr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .size_code_i(size), .mrbl_i(mrbl),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .tx_fetch_i(tx_fetch), .tx_done_i(tx_done), .tx_csl_i(tx_csl),
    .tx_desc_valid_o(tx_valid), .tx_stall_o(tx_stall), .tx_len_o(tx_len),
    .tx_addr_o(tx_addr), .tx_last_o(tx_last), .tx_len_err_o(tx_err),
    .rx_frame_i(rx_frame), .rx_frame_len_i(rx_len),
    .rx_buf_valid_o(rx_valid), .rx_buf_len_o(rx_blen), .rx_buf_addr_o(rx_baddr),
    .rx_buf_err_o(rx_err), .rx_busy_o(rx_busy), .rx_stall_o(rx_stall)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic hw(input int idx, input int w, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 9'(idx * 4 + w); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input int idx, input int w, output logic [15:0] d);
    @(negedge clk);
    host_addr = 9'(idx * 4 + w);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wr_bd(input int idx, input logic [15:0] w0, input logic [15:0] w1,
                       input logic [15:0] w2, input logic [15:0] w3);
    hw(idx, 0, w0); hw(idx, 1, w1); hw(idx, 2, w2); hw(idx, 3, w3);
  endtask

  task automatic fetch();
    @(negedge clk); tx_fetch = 1'b1;
    @(negedge clk); tx_fetch = 1'b0;
  endtask

  task automatic done(input logic csl);
    @(negedge clk); tx_done = 1'b1; tx_csl = csl;
    @(negedge clk); tx_done = 1'b0; tx_csl = 1'b0;
  endtask

  task automatic set_size(input int c);
    @(negedge clk); size = 2'(c);
    @(negedge clk);
  endtask

  task automatic rx_run(input int len);
    int guard;
    got_n = 0; guard = 0;
    @(negedge clk); rx_frame = 1'b1; rx_len = 16'(len);
    @(negedge clk); rx_frame = 1'b0;
    while ((rx_busy || rx_valid) && guard < 2000) begin
      if (rx_valid && got_n < 64) begin
        got_len[got_n] = rx_blen; got_addr[got_n] = rx_baddr; got_err[got_n] = rx_err;
        got_n++;
      end
      guard++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    finish_test();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !tx_stall && !rx_busy && !rx_valid && !rx_stall, "reset",
        {tx_valid, tx_stall, rx_busy, rx_valid, rx_stall}, 0);

    // R12 host port
    hw(127, 3, 16'h5A5A);
    hr(127, 3, rd);
    chk(rd == 16'h5A5A, "R12", rd, 16'h5A5A);
    hr(0, 0, rd);
    chk(rd == 16'h0000, "R12 cleared", rd, 0);

    for (int c = 0; c < 4; c++) begin
      int ntx;
      ntx = 8 << c;
      set_size(c);
      mrbl = 16'd64;
      for (int i = 0; i < ntx; i++)
        wr_bd(i, 16'hC000, 16'(i + 1), 16'(i * 3 + c), 16'(16'hA000 + c));
      for (int i = 0; i < ntx; i++) begin
        fetch();
        chk(tx_valid && tx_len == 16'(i + 1), (i == 0 && c > 0) ? "R3 tx" : "R1 tx",
            tx_len, i + 1);
        chk(tx_addr == {16'(16'hA000 + c), 16'(i * 3 + c)} && tx_last && !tx_err, "R4",
            tx_addr, {16'(16'hA000 + c), 16'(i * 3 + c)});
        done(1'(i % 2));
        hr(i, 0, rd);
        chk(rd == (16'h4000 | 16'(i % 2)), "R8", rd, 16'h4000 | 16'(i % 2));
      end
      fetch();
      chk(tx_stall && !tx_valid, "R6", {tx_stall, tx_valid}, 2'b10);
      hw(0, 0, 16'hC000);
      fetch();
      chk(tx_valid && tx_len == 16'd1, "R2 tx wrap", tx_len, 1);
      done(1'b0);

      for (int j = 0; j < 3; j++)
        wr_bd(ntx + j, 16'h8000, 16'h0000, 16'(16'h0100 + 2 * j), 16'h0001);
      rx_run(150);
      chk(got_n == 3, "R9 count", got_n, 3);
      chk(got_len[0] == 16'd64 && got_len[1] == 16'd64 && got_len[2] == 16'd22, "R9 lens",
          {got_len[0], got_len[1], got_len[2]}, {16'd64, 16'd64, 16'd22});
      chk(got_addr[0] == 32'h0001_0100 && !got_err[0], c > 0 ? "R3 rx" : "R1 rx",
          got_addr[0], 32'h0001_0100);
      hr(ntx, 1, rd);
      chk(rd == 16'd64, "R1 rx start", rd, 64);
      hr(ntx, 0, rd);
      chk(rd == 16'h0000, "R9 mid status", rd, 0);
      hr(ntx + 2, 0, rd);
      chk(rd == 16'h4000, "R9 last status", rd, 16'h4000);
      hr(ntx + 2, 1, rd);
      chk(rd == 16'd22, "R9 last len", rd, 22);
    end

    // receive wrap and stall, code 3: pointer at descriptor 67
    mrbl = 16'd16;
    for (int j = 64; j < 128; j++) wr_bd(j, 16'h8000, 16'h0000, 16'(2 * j), 16'h0000);
    rx_run(16 * 61);
    chk(got_n == 61, "R9 long frame", got_n, 61);
    rx_run(10);
    chk(got_n == 1 && got_len[0] == 16'd10, "R2 rx wrap", got_len[0], 10);
    hr(64, 1, rd);
    chk(rd == 16'd10, "R2 rx wrap desc", rd, 10);
    hw(65, 0, 16'h0000);
    @(negedge clk); rx_frame = 1'b1; rx_len = 16'd5;
    @(negedge clk); rx_frame = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_stall && rx_busy && !rx_valid, "R11 stall", {rx_stall, rx_busy, rx_valid}, 3'b110);
    hr(65, 1, rd);
    chk(rd == 16'd0, "R11 untouched", rd, 0);
    hw(65, 0, 16'h8000);
    got_n = 0;
    for (int k = 0; k < 10; k++) begin
      if (rx_valid) begin got_len[0] = rx_blen; got_n++; end
      @(negedge clk);
    end
    chk(got_n == 1 && got_len[0] == 16'd5 && !rx_busy, "R11 resume", got_len[0], 5);

    // R10 odd receive address, code 0: pointer reset to descriptor 8
    set_size(0);
    mrbl = 16'd64;
    wr_bd(8, 16'h8000, 16'h0000, 16'h0101, 16'h0000);
    rx_run(20);
    chk(got_n == 1 && got_err[0] && got_len[0] == 16'd20, "R10 port", got_err[0], 1);
    hr(8, 0, rd);
    chk(rd == 16'h4004, "R10 status", rd, 16'h4004);

    // R7 open-frame limit and R5 zero length
    set_size(1);
    set_size(0);
    wr_bd(0, 16'h8000, 16'd5, 16'h0000, 16'h0000);
    wr_bd(1, 16'hC000, 16'd6, 16'h0000, 16'h0000);
    wr_bd(2, 16'hC000, 16'd7, 16'h0000, 16'h0000);
    wr_bd(3, 16'hC000, 16'd8, 16'h0000, 16'h0000);
    wr_bd(4, 16'hC000, 16'd0, 16'h0000, 16'h0000);
    fetch(); chk(tx_valid && tx_len == 16'd5 && !tx_last, "R7 f0", tx_len, 5);
    fetch(); chk(tx_valid && tx_len == 16'd6 && tx_last, "R7 f1", tx_len, 6);
    fetch(); chk(tx_valid && tx_len == 16'd7, "R7 f2", tx_len, 7);
    fetch(); chk(tx_stall && !tx_valid, "R7 third frame", tx_stall, 1);
    done(1'b1);
    fetch(); chk(tx_stall && !tx_valid, "R7 still two", tx_stall, 1);
    hr(0, 0, rd);
    chk(rd == 16'h0000, "R8 csl not on middle", rd, 0);
    done(1'b1);
    hr(1, 0, rd);
    chk(rd == 16'h4001, "R8 csl on last", rd, 16'h4001);
    fetch(); chk(tx_valid && tx_len == 16'd8, "R7 released", tx_len, 8);
    done(1'b0);
    done(1'b0);
    fetch(); chk(tx_valid && tx_err && tx_len == 16'd0, "R5 zero len", tx_err, 1);
    done(1'b0);
    hr(4, 1, rd);
    chk(rd == 16'd0, "R5 len kept", rd, 0);
    hr(3, 1, rd);
    chk(rd == 16'd8, "R5 len unchanged", rd, 8);

    finish_test();
  end
endmodule